// File: doc/BRIEF.md
# Serial-Loaded Control Latch

This block holds a small set of control lines, such as an audio mute release and a video decoder disable, and lets a host load them over three wires: serial data, a shift clock and a load strobe. The host keeps the strobe low and presents one bit on the data wire while the shift clock is low. It then raises the shift clock so that the block takes the bit. It sends the most significant bit first, for four bits. It then returns the clock and data wires low and pulses the strobe high and back low. On the rising edge of the strobe, the word in the shift register is copied to the parallel outputs.

The three wires may be driven with no relation to the system clock. Each wire passes through a synchronizer chain, and the rising edges of the shift clock and of the strobe become single-cycle pulses in the system clock domain. The parallel outputs come from a register that changes only on a strobe edge. They therefore stay free of glitches while a new word is shifted in behind them.

Top module: `serial_ctrl_latch`

## Requirements
- R1: While reset is high, and on the first cycle after it, the output word is all zeros (zero is the muted, decoder-enabled safe state).
- R2: After four shift-clock rising edges with data bits b3, b2, b1, b0 in that order, a strobe rising edge makes the output {b3,b2,b1,b0}, with b3 on output bit 3.
- R3: A bit is taken only on a rising edge of the shift clock; a data change while the clock is high, and the falling edge of the clock, have no effect on the word that is loaded.
- R4: The output does not change while bits are being shifted in, until the next strobe rising edge.
- R5: Only the rising edge of the strobe updates the output; its falling edge, and shifting while the strobe is held high, leave the output unchanged.
- R6: If more than four bits are shifted before a strobe, the four most recent bits are loaded.
- R7: After a load, the output holds its value through the strobe falling edge and any later shifting until the next strobe rising edge.
- R8: The output changes on the (SYNC_STAGES+1)th system clock rising edge after the strobe input goes high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial data wire, asynchronous |
| ser_sck_i | input | 1 | Shift clock wire, asynchronous |
| ser_load_i | input | 1 | Load strobe wire, asynchronous |
| ctl_q_o | output | WORD_W | Latched control word |

## Verification
The bench changes the data wire while the shift clock is high. A design that sampled on levels or on falling edges would then load the inverted bits. It shifts six bits before a strobe, so a design that counted bits or kept the oldest ones would load the wrong word. It holds the strobe high across a second word and then releases it, which catches a latch that follows the strobe level or fires on both edges. A cycle-exact strobe-to-output probe would reveal a synchronizer with a stage too many or too few, and mid-shift probes would reveal outputs that were not held.

// File: rtl/scl_pkg.sv
package scl_pkg;
  // Index of each wire inside the synchronized pin vector
  localparam int PIN_DATA = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_LD   = 2;
  localparam int PIN_CNT  = 3;

  // Events presented to the shift and latch stages, all in the clk domain
  typedef struct packed {
    logic data;      // synchronized data level, aligned with the clock chain
    logic sck_rise;  // one-cycle pulse on a shift clock rising edge
    logic ld_rise;   // one-cycle pulse on a load strobe rising edge
  } ser_evt_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync
  import scl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PIN_CNT-1:0]  pins_i,
  output ser_evt_t            evt_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][PIN_CNT-1:0] chain;
  logic [PIN_CNT-1:0]             prev;
  logic [PIN_CNT-1:0]             rise;

  // Synchronizer chain: every wire passes through the same depth so the
  // data level stays aligned with the clock edge that samples it.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= '0;
    end else begin
      chain[0] <= pins_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[LAST];
    end
  end

  assign rise = chain[LAST] & ~prev;

  assign evt_o.data     = chain[LAST][PIN_DATA];
  assign evt_o.sck_rise = rise[PIN_SCK];
  assign evt_o.ld_rise  = rise[PIN_LD];

  // R3
  sck_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o.sck_rise |=> !evt_o.sck_rise);

  // R5
  ld_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o.ld_rise |=> !evt_o.ld_rise);
endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sreg;

  // New bits enter at bit 0, so the first bit sent ends at the top
  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (shift_en) sreg <= {sreg[WORD_W-2:0], din};
  end

  assign word_o = sreg;

  // R3
  shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sreg));

  // R6
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sreg[0] == $past(din)) &&
                 (sreg[WORD_W-1:1] == $past(sreg[WORD_W-2:0])));
endmodule

// File: rtl/scl_latch.sv
module scl_latch #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)          q_o <= '0;
    else if (load_en) q_o <= word_i;
  end

  // R1
  reset_safe_chk: assert property (@(posedge clk)
    rst |=> (q_o == '0));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(q_o));

  // R2
  latch_take_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q_o == $past(word_i)));
endmodule

// File: rtl/serial_ctrl_latch.sv
module serial_ctrl_latch
  import scl_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data_i,
  input  logic              ser_sck_i,
  input  logic              ser_load_i,
  output logic [WORD_W-1:0] ctl_q_o
);
  logic [PIN_CNT-1:0] pins;
  ser_evt_t           evt;
  logic [WORD_W-1:0]  shifted;

  always_comb begin
    pins           = '0;
    pins[PIN_DATA] = ser_data_i;
    pins[PIN_SCK]  = ser_sck_i;
    pins[PIN_LD]   = ser_load_i;
  end

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pins_i (pins),
    .evt_o  (evt)
  );

  scl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (evt.sck_rise),
    .din      (evt.data),
    .word_o   (shifted)
  );

  scl_latch #(.WORD_W(WORD_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .load_en (evt.ld_rise),
    .word_i  (shifted),
    .q_o     (ctl_q_o)
  );
endmodule

// File: tb/sim_serial_ctrl_latch.sv
module sim_serial_ctrl_latch;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int SYNC       = 2;
  localparam int GAP        = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd  = 1'b0;
  logic sck = 1'b0;
  logic ld  = 1'b0;
  logic [W-1:0] q;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctrl_latch #(.WORD_W(W), .SYNC_STAGES(SYNC)) u0 (
    .clk        (clk),
    .rst        (rst),
    .ser_data_i (sd),
    .ser_sck_i  (sck),
    .ser_load_i (ld),
    .ctl_q_o    (q)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One bit: data set while clock low, then a clock pulse.
  // If flip is set, data inverts while the clock is high.
  task automatic send_bit(input logic b, input logic flip);
    @(negedge clk); sd = b; sck = 1'b0; idle(GAP);
    sck = 1'b1; idle(GAP);
    if (flip) begin sd = ~b; idle(GAP); end
    sck = 1'b0; idle(GAP);
  endtask

  task automatic send_bits(input logic [7:0] bits, input int n, input logic flip);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i], flip);
    sd = 1'b0; idle(GAP);
  endtask

  task automatic strobe();
    @(negedge clk); ld = 1'b1; idle(GAP);
    ld = 1'b0; idle(GAP);
  endtask

  task automatic t_reset();
    check("R1 during reset", q, '0);
    @(negedge clk); rst = 1'b0;
    check("R1 after reset", q, '0);
    idle(GAP);
  endtask

  task automatic t_basic();
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    check("R4 mid-shift", q, 4'b0000);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    check("R4 before strobe", q, 4'b0000);
    strobe();
    check("R2 word 1011", q, 4'b1011);
    send_bits(8'h04, 4, 1'b0);
    check("R7 held while shifting", q, 4'b1011);
    strobe();
    check("R2 word 0100", q, 4'b0100);
  endtask

  task automatic t_patterns();
    logic [W-1:0] pats [4] = '{4'b0101, 4'b1111, 4'b1000, 4'b0000};
    foreach (pats[k]) begin
      send_bits({4'b0, pats[k]}, 4, 1'b0);
      strobe();
      check("R2 pattern", q, pats[k]);
    end
  endtask

  task automatic t_edge_only();
    send_bits(8'h09, 4, 1'b1);
    strobe();
    check("R3 data flipped while clock high", q, 4'b1001);
  endtask

  task automatic t_overflow();
    send_bits(8'b00110010, 6, 1'b0);
    strobe();
    check("R6 six bits keep last four", q, 4'b0010);
  endtask

  task automatic t_strobe_level();
    send_bits(8'h0c, 4, 1'b0);
    @(negedge clk); ld = 1'b1; idle(GAP);
    check("R5 load on rise", q, 4'b1100);
    send_bits(8'h03, 4, 1'b0);
    check("R5 shifting with strobe high", q, 4'b1100);
    @(negedge clk); ld = 1'b0; idle(GAP);
    check("R5 strobe fall no update", q, 4'b1100);
    @(negedge clk); ld = 1'b1; idle(GAP);
    ld = 1'b0; idle(GAP);
    check("R5 next rise loads", q, 4'b0011);
  endtask

  task automatic t_latency();
    send_bits(8'h0a, 4, 1'b0);
    @(negedge clk); ld = 1'b1;
    for (int i = 0; i < SYNC; i++) @(posedge clk);
    @(negedge clk);
    check("R8 not yet updated", q, 4'b0011);
    @(posedge clk); @(negedge clk);
    check("R8 updated on time", q, 4'b1010);
    ld = 1'b0; idle(GAP);
    check("R7 held after fall", q, 4'b1010);
  endtask

  initial begin
    fork
      begin
        idle(3);
        t_reset();
        t_basic();
        t_patterns();
        t_edge_only();
        t_overflow();
        t_strobe_level();
        t_latency();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule